// File: doc/BRIEF.md
# HyperBus Single-Word Memory Controller

This block connects a simple request/acknowledge register bus carrying one 32-bit word at a time to an eight-bit double-data-rate HyperBus memory. For each accepted request it drives the memory clock and chip select. It sends a six-byte command/address header on the data lane and waits a fixed access latency. It then moves the word as four bytes, one per memory clock edge, either driving them out or sampling them in. The data lane and the read/write data strobe each have their own output-enable, so the pads can be tri-stated outside the cycles in which the controller owns them.

The memory clock runs at one quarter of the system clock. Every byte is held for two system cycles, and the clock edges fall in the middle of each byte. All pin outputs come straight from flip-flops. A bus master raises the request with the address, direction and write data, and keeps it up until it sees the one-cycle acknowledge. For reads, the assembled word is valid on the read data output in the acknowledge cycle.

Cycle numbering used below: cycle t of a transaction is the system clock cycle that follows the t-th rising edge after the edge that accepted the request (cycle 0 directly follows the accepting edge).

Top module: `hb_ctrl`

## Requirements
- R1: After reset and whenever no transaction is running, mem_cs_n is 1, mem_clk is 0, mem_dq_oe is 0, mem_rwds_oe is 0 and bus_ack is 0.
- R2: mem_clk is high in cycles t with 3 <= t <= 64 and (t-3) mod 4 in {0,1}, and low in every other cycle. This gives sixteen rising edges, each in the middle of a byte.
- R3: mem_cs_n is 0 in cycles 2 through 65 (64 cycles) and 1 in cycles 0, 1 and 66.
- R4: mem_dq_oe is 1 in cycles 2 through 13. Header byte k (k = 0..5) is on mem_dq_out in cycles 2+2k and 3+2k and is header bits [47-8k : 40-8k], so the most significant byte goes first.
- R5: The header has bit 47 = 1 for a read (bus_we = 0) and 0 for a write, bit 46 = 0, bit 45 = 1 (linear burst), bits 44:16 = bus_addr[30:2] and bits 15:0 = 0. For example, a write to 0x1234 sends 20 00 04 8D 00 00 and a read from 0x1234 starts with A0.
- R6: In cycles 14 through 57 (44 cycles) mem_dq_oe and mem_rwds_oe are 0 while mem_cs_n stays 0. The data phase starts in cycle 58.
- R7: In a write, cycles 58 through 65 have mem_dq_oe = 1, mem_rwds_oe = 1 and mem_rwds_out = 0. Data byte j (j = 0..3) is bus_wdata[31-8j : 24-8j], held in cycles 58+2j and 59+2j. mem_rwds_out is 0 at all times.
- R8: In a read, mem_dq_oe and mem_rwds_oe stay 0 from cycle 14 on. mem_dq_in is sampled at the rising edge that ends cycle 59+2j and placed in bus_rdata[31-8j : 24-8j]. Values on mem_dq_in in any other cycle have no effect.
- R9: bus_ack is 1 in cycle 66 only, the first cycle with mem_cs_n back at 1. For a read, bus_rdata holds the assembled word in that cycle.
- R10: bus_we, bus_addr and bus_wdata are taken at the accepting edge, and later changes to them have no effect on the transaction. A request held high during a transaction is not accepted again before the edge that ends cycle 66. Once the request is dropped, the controller stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Transfer request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the word |
| bus_wdata | input | 32 | Word to write |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Word read, valid with bus_ack |
| mem_clk | output | 1 | Memory clock, quarter system rate |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_dq_out | output | 8 | Data lane value to drive |
| mem_dq_oe | output | 1 | Data lane output-enable |
| mem_dq_in | input | 8 | Data lane value from the pads |
| mem_rwds_out | output | 1 | Strobe value to drive (always low) |
| mem_rwds_oe | output | 1 | Strobe output-enable |

## Verification
Writes and reads are run across several address patterns: a small mid-range address, the all-ones top address, address zero, an address with only the two byte-offset bits set, and a mixed high address. Together these separate the direction bit, the fixed burst bit, the truncation of the top address bit and the discarding of the byte offset in the header. Word values with distinct bytes expose any byte-order or slot error. During reads the data lane carries a changing filler byte outside the four sampling slots, so sampling one cycle early or late returns a visibly wrong word. The bus inputs are scrambled right after acceptance and the request is left high for the whole transfer, which shows both that the inputs are captured and that re-acceptance is held off. A chained write-then-read pair checks that a new transfer begins on the edge right after the acknowledge cycle.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Width of one transfer on the memory data lane.
    localparam int unsigned HB_BYTE_W = 8;

    // Fixed header bit positions, counted from the top of the header word.
    localparam int unsigned HB_RD_OFS    = 1;   // read / not-write flag
    localparam int unsigned HB_LIN_OFS   = 3;   // linear burst flag
    localparam int unsigned HB_LOW_PAD_W = 16;  // zero bits below the word address

endpackage

// File: rtl/hb_ca_gen.sv
module hb_ca_gen
    import hb_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CA_W   = 48
) (
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output logic [CA_W-1:0]   ca
);
    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam int unsigned SLOT_W = CA_W - HB_LIN_OFS - HB_LOW_PAD_W;

    logic [WORD_W-1:0] word_addr;
    logic [ADDR_W-1:0] addr_unused_view;

    assign word_addr        = addr[ADDR_W-1:2];
    assign addr_unused_view = addr;

    always_comb begin
        ca = '0;
        ca[CA_W-HB_RD_OFS]  = rd;
        ca[CA_W-HB_LIN_OFS] = 1'b1;
        for (int i = 0; i < SLOT_W; i++) begin
            if (i < WORD_W) begin
                ca[HB_LOW_PAD_W+i] = word_addr[i];
            end
        end
    end

endmodule

// File: rtl/hb_seq_timer.sv
module hb_seq_timer #(
    parameter int unsigned CW     = 7,
    parameter int unsigned T_LAST = 65
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    output logic          take,
    output logic          act_q,
    output logic          act_d,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d,
    output logic          done_q
);
    typedef struct packed {
        logic          act;
        logic          done;
        logic [CW-1:0] cnt;
    } tmr_t;

    localparam logic [CW-1:0] C_LAST = CW'(T_LAST);

    tmr_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        take     = 1'b0;
        if (!s_q.act) begin
            if (req) begin
                take    = 1'b1;
                s_d.act = 1'b1;
                s_d.cnt = '0;
            end
        end else if (s_q.cnt == C_LAST) begin
            s_d.act  = 1'b0;
            s_d.done = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_q  = s_q.act;
    assign act_d  = s_d.act;
    assign cnt_q  = s_q.cnt;
    assign cnt_d  = s_d.cnt;
    assign done_q = s_q.done;

    // Sequence position advances by exactly one system cycle while running.
    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && $past(act_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

    // A fresh transaction always starts from position zero.
    assert_start_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q) |-> (cnt_q == '0));

    // Completion lasts exactly one cycle.
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // Completion and a running sequence never overlap.
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !act_q);

endmodule

// File: rtl/hb_lane_io.sv
module hb_lane_io
    import hb_pkg::*;
#(
    parameter int unsigned CW       = 7,
    parameter int unsigned CA_BYTES = 6,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned T_CA     = 2,
    parameter int unsigned T_WAIT   = 14,
    parameter int unsigned T_DATA   = 58,
    parameter int unsigned T_TAIL   = 66
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          act_d,
    input  logic [CW-1:0]                 cnt_d,
    input  logic                          act_q,
    input  logic [CW-1:0]                 cnt_q,
    input  logic                          we,
    input  logic [CA_BYTES*HB_BYTE_W-1:0] ca,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [HB_BYTE_W-1:0]          dq_in,
    output logic                          mem_clk,
    output logic                          cs_n,
    output logic [HB_BYTE_W-1:0]          dq_out,
    output logic                          dq_oe,
    output logic                          rwds_oe,
    output logic [DATA_W-1:0]             rd_word
);
    localparam int unsigned DBYTES = DATA_W / HB_BYTE_W;
    localparam int unsigned CA_W   = CA_BYTES * HB_BYTE_W;

    localparam logic [CW-1:0] C_CA    = CW'(T_CA);
    localparam logic [CW-1:0] C_WAIT  = CW'(T_WAIT);
    localparam logic [CW-1:0] C_DATA  = CW'(T_DATA);
    localparam logic [CW-1:0] C_TAIL  = CW'(T_TAIL);
    localparam logic [CW-1:0] C_CK0   = CW'(T_CA + 1);
    localparam logic [CW-1:0] C_CKEND = CW'(T_TAIL - 2);

    typedef struct packed {
        logic                 ck;
        logic                 cs_n;
        logic                 dq_oe;
        logic                 rwds_oe;
        logic [HB_BYTE_W-1:0] dq;
        logic [DATA_W-1:0]    rd;
    } lane_t;

    localparam lane_t LANE_RST = '{ck: 1'b0, cs_n: 1'b1, dq_oe: 1'b0,
                                   rwds_oe: 1'b0, dq: '0, rd: '0};

    logic [HB_BYTE_W-1:0] ca_byte [CA_BYTES];
    logic [HB_BYTE_W-1:0] wd_byte [DBYTES];

    for (genvar k = 0; k < CA_BYTES; k++) begin : g_ca_byte
        assign ca_byte[k] = ca[CA_W-1-HB_BYTE_W*k -: HB_BYTE_W];
    end

    for (genvar j = 0; j < DBYTES; j++) begin : g_wd_byte
        assign wd_byte[j] = wdata[DATA_W-1-HB_BYTE_W*j -: HB_BYTE_W];
    end

    lane_t l_d, l_q;
    logic  in_ca, in_dat, in_cs, cap_slot;

    always_comb begin
        in_ca  = act_d && (cnt_d >= C_CA) && (cnt_d < C_WAIT);
        in_dat = act_d && (cnt_d >= C_DATA) && (cnt_d < C_TAIL);
        in_cs  = act_d && (cnt_d >= C_CA) && (cnt_d < C_TAIL);
        cap_slot = act_q && !we && (cnt_q >= C_DATA) && (cnt_q < C_TAIL)
                   && (((cnt_q - C_DATA) & CW'(1)) != '0);

        l_d         = l_q;
        l_d.ck      = act_d && (cnt_d >= C_CK0) && (cnt_d <= C_CKEND)
                      && ((((cnt_d - C_CK0) >> 1) & CW'(1)) == '0);
        l_d.cs_n    = !in_cs;
        l_d.dq_oe   = in_ca || (in_dat && we);
        l_d.rwds_oe = in_dat && we;
        l_d.dq      = '0;
        for (int k = 0; k < CA_BYTES; k++) begin
            if (in_ca && (((cnt_d - C_CA) >> 1) == CW'(k))) begin
                l_d.dq = ca_byte[k];
            end
        end
        for (int j = 0; j < DBYTES; j++) begin
            if (in_dat && we && (((cnt_d - C_DATA) >> 1) == CW'(j))) begin
                l_d.dq = wd_byte[j];
            end
        end
        if (cap_slot) begin
            l_d.rd = {l_q.rd[DATA_W-HB_BYTE_W-1:0], dq_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= LANE_RST;
        end else begin
            l_q <= l_d;
        end
    end

    assign mem_clk = l_q.ck;
    assign cs_n    = l_q.cs_n;
    assign dq_oe   = l_q.dq_oe;
    assign rwds_oe = l_q.rwds_oe;
    assign dq_out  = l_q.dq;
    assign rd_word = l_q.rd;

    // The memory clock only moves while the device is selected.
    assert_clk_in_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        l_q.ck |-> !l_q.cs_n);

    // Every memory clock edge falls in the middle of a held byte.
    assert_byte_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(l_q.ck) || $fell(l_q.ck)) |-> $stable(l_q.dq));

    // The strobe is only driven together with write data.
    assert_strobe_with_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        l_q.rwds_oe |-> l_q.dq_oe);

    // The data lane is only driven while selected.
    assert_oe_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        l_q.dq_oe |-> !l_q.cs_n);

endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
    import hb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned LEAD_CYC = 2,
    parameter int unsigned CA_BYTES = 6,
    parameter int unsigned LAT_CYC  = 44
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 bus_ack,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 mem_clk,
    output logic                 mem_cs_n,
    output logic [HB_BYTE_W-1:0] mem_dq_out,
    output logic                 mem_dq_oe,
    input  logic [HB_BYTE_W-1:0] mem_dq_in,
    output logic                 mem_rwds_out,
    output logic                 mem_rwds_oe
);
    localparam int unsigned DBYTES = DATA_W / HB_BYTE_W;
    localparam int unsigned CA_W   = CA_BYTES * HB_BYTE_W;
    localparam int unsigned T_CA   = LEAD_CYC;
    localparam int unsigned T_WAIT = T_CA + 2 * CA_BYTES;
    localparam int unsigned T_DATA = T_WAIT + LAT_CYC;
    localparam int unsigned T_TAIL = T_DATA + 2 * DBYTES;
    localparam int unsigned CW     = $clog2(T_TAIL + 1);

    typedef struct packed {
        logic              we;
        logic [CA_W-1:0]   ca;
        logic [DATA_W-1:0] wd;
    } cap_t;

    logic            take, act_q, act_d, done_q;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [CA_W-1:0] ca_live;
    cap_t            cap_d, cap_q;

    hb_ca_gen #(
        .ADDR_W (ADDR_W),
        .CA_W   (CA_W)
    ) ca_gen_i (
        .rd   (!bus_we),
        .addr (bus_addr),
        .ca   (ca_live)
    );

    hb_seq_timer #(
        .CW     (CW),
        .T_LAST (T_TAIL - 1)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_req),
        .take   (take),
        .act_q  (act_q),
        .act_d  (act_d),
        .cnt_q  (cnt_q),
        .cnt_d  (cnt_d),
        .done_q (done_q)
    );

    always_comb begin
        cap_d = cap_q;
        if (take) begin
            cap_d.we = bus_we;
            cap_d.ca = ca_live;
            cap_d.wd = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    hb_lane_io #(
        .CW       (CW),
        .CA_BYTES (CA_BYTES),
        .DATA_W   (DATA_W),
        .T_CA     (T_CA),
        .T_WAIT   (T_WAIT),
        .T_DATA   (T_DATA),
        .T_TAIL   (T_TAIL)
    ) lane_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_d   (act_d),
        .cnt_d   (cnt_d),
        .act_q   (act_q),
        .cnt_q   (cnt_q),
        .we      (cap_q.we),
        .ca      (cap_q.ca),
        .wdata   (cap_q.wd),
        .dq_in   (mem_dq_in),
        .mem_clk (mem_clk),
        .cs_n    (mem_cs_n),
        .dq_out  (mem_dq_out),
        .dq_oe   (mem_dq_oe),
        .rwds_oe (mem_rwds_oe),
        .rd_word (bus_rdata)
    );

    assign bus_ack      = done_q;
    assign mem_rwds_out = 1'b0;

    // Acknowledge comes in the first cycle with the device deselected.
    assert_ack_after_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (mem_cs_n && !$past(mem_cs_n)));

    // A deselected device sees no clock and no driven lanes.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (!mem_dq_oe && !mem_rwds_oe && !mem_clk));

    // No new acceptance while a transaction runs.
    assert_no_reaccept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !$past(take)) |-> $stable(cap_q));

endmodule

// File: tb/hb_ctrl_tb_top.sv
`timescale 1ns/1ps
module hb_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        mem_clk, mem_cs_n, mem_dq_oe, mem_rwds_out, mem_rwds_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    hb_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_ack      (bus_ack),
        .bus_rdata    (bus_rdata),
        .mem_clk      (mem_clk),
        .mem_cs_n     (mem_cs_n),
        .mem_dq_out   (mem_dq_out),
        .mem_dq_oe    (mem_dq_oe),
        .mem_dq_in    (mem_dq_in),
        .mem_rwds_out (mem_rwds_out),
        .mem_rwds_oe  (mem_rwds_oe)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;   // write word, or word the memory returns on a read
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{we: 1'b1, addr: 32'h0000_1234, data: 32'hDEAD_BEEF},
        '{we: 1'b0, addr: 32'h0000_1234, data: 32'hDEAD_BEEF},
        '{we: 1'b1, addr: 32'hFFFF_FFFC, data: 32'h0102_0304},
        '{we: 1'b0, addr: 32'h0000_0000, data: 32'h8000_0001},
        '{we: 1'b1, addr: 32'h0000_0003, data: 32'h0000_0000},
        '{we: 1'b0, addr: 32'hABCD_EF00, data: 32'hFF00_5AA5}
    };

    task automatic check(input string req, input string what, input int t,
                         input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s cycle=%0d got=%0h expected=%0h", req, what, t, act, exp);
        end
    endtask

    task automatic idle_checks(input string req, input int t);
        check(req, "cs_n", t, mem_cs_n, 1'b1);
        check(req, "mem_clk", t, mem_clk, 1'b0);
        check(req, "dq_oe", t, mem_dq_oe, 1'b0);
        check(req, "rwds_oe", t, mem_rwds_oe, 1'b0);
        check(req, "ack", t, bus_ack, 1'b0);
    endtask

    // One transfer, checked in every cycle 0..66 at the falling edge.
    task automatic run_txn(input logic we, input logic [31:0] a, input logic [31:0] wd,
                           input logic [31:0] rw, input bit pre, input bit keep,
                           input logic nwe, input logic [31:0] na, input logic [31:0] nwd);
        logic [47:0] ca;
        logic        e_cs, e_ck, e_ca, e_dat, e_oe;
        string       oe_tag;
        ca        = '0;
        ca[47]    = !we;
        ca[45]    = 1'b1;
        ca[44:16] = a[30:2];
        if (!pre) begin
            @(negedge clk);
            bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        end
        for (int t = 0; t <= 66; t++) begin
            @(negedge clk);
            if (t == 0) begin
                // R10: scramble the bus fields; the captured copy must be used
                bus_we = !we; bus_addr = ~a; bus_wdata = ~wd;
            end
            e_cs  = !(t >= 2 && t <= 65);
            e_ck  = (t >= 3 && t <= 64 && ((t - 3) % 4) < 2);
            e_ca  = (t >= 2 && t <= 13);
            e_dat = (t >= 58 && t <= 65);
            e_oe  = e_ca || (we && e_dat);
            oe_tag = e_ca ? "R4" : ((t >= 14 && t <= 57) ? "R6" : (we ? "R7" : "R8"));
            check("R3", "cs_n", t, mem_cs_n, e_cs);
            check("R2", "mem_clk", t, mem_clk, e_ck);
            check(oe_tag, "dq_oe", t, mem_dq_oe, e_oe);
            check(oe_tag, "rwds_oe", t, mem_rwds_oe, we && e_dat);
            check("R7", "rwds_out", t, mem_rwds_out, 1'b0);
            if (e_ca)
                check("R5", "header byte", t, mem_dq_out, ca[47-8*((t-2)/2) -: 8]);
            if (we && e_dat)
                check("R7", "write byte", t, mem_dq_out, wd[31-8*((t-58)/2) -: 8]);
            check("R9", "ack", t, bus_ack, t == 66);
            if (t == 66 && !we)
                check("R8", "read word", t, bus_rdata, rw);
            if (!we && e_dat)
                mem_dq_in = rw[31-8*((t-58)/2) -: 8];
            else
                mem_dq_in = 8'h3C ^ 8'(t);
            if (t == 66) begin
                if (keep) begin
                    bus_we = nwe; bus_addr = na; bus_wdata = nwd;
                end else begin
                    bus_req = 1'b0;
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete got=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: state held during reset, with a request already raised
        bus_req = 1'b1;
        repeat (3) @(negedge clk);
        idle_checks("R1", -1);
        bus_req = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        idle_checks("R1", -1);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            run_txn(VECS[v].we, VECS[v].addr, VECS[v].data, VECS[v].data,
                    1'b0, 1'b0, 1'b0, '0, '0);
            // R10: request dropped, controller must stay idle
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                idle_checks("R10", 67 + k);
            end
        end

        // Chained pair: request left high through the acknowledge cycle
        run_txn(1'b1, 32'h0000_2468, 32'hCAFE_F00D, 32'h0,
                1'b0, 1'b1, 1'b0, 32'h0000_2468, 32'h0);
        run_txn(1'b0, 32'h0000_2468, 32'h0, 32'h1357_9BDF,
                1'b1, 1'b0, 1'b0, '0, '0);
        @(negedge clk);
        idle_checks("R1", 67);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule